// File: doc/BRIEF.md
# Write-Update Coherent Cache Cluster

This block keeps a group of small private caches coherent by sending every store to all of them instead of killing other copies. Each core has a direct-mapped, single-word-line cache whose lines are either valid or invalid. A store travels over one shared broadcast bus that carries the line address, the new value and the id of the sender. Every cache that holds a valid copy of that address takes the new value. The sender allocates the line if it did not already have it. The backing memory is written by the same bus cycle.

Loads that hit are answered from the local cache and never use the bus. Loads that miss use the bus to read memory and then mark the line valid. Only one bus transaction happens per cycle, and the lowest core index wins when several cores ask at once. Every cache and the memory therefore apply stores in the same global order. The sender's own copy is also written when its broadcast appears on the bus, not when the store is accepted, which keeps that order intact.

Each core talks to the cluster with a hold-until-response request port. Memory is reached through one write port and one read port. The read port returns data one cycle after the read enable.

Top module: `wu_coherent_cluster`

## Requirements
- R1: After reset every line of every cache is invalid, no response is pending and neither memory enable is asserted, so the first load of any address reads memory.
- R2: A load that hits answers with `resp_valid` one cycle after it is accepted, starts no bus transaction, and every response is a single-cycle pulse.
- R3: A load that misses asserts `mem_rd_en` once with its address, returns the memory word, and leaves the line valid so that a repeated load hits.
- R4: Every store produces exactly one bus cycle in which `mem_wr_en` is high with the store's address and data.
- R5: A cache that holds a valid copy of a stored address replaces its copy with the broadcast value, and a later load there hits and returns the new value.
- R6: A cache that does not hold a stored address leaves its lines unchanged and does not allocate that address.
- R7: A store that misses allocates the line in the storing cache, and a later load by that core hits.
- R8: When several cores request the bus in the same cycle, they are granted one per cycle in ascending core index. Memory sees their stores in that order, and all caches end up holding the value of the last store.
- R9: No bus transaction is granted in the cycle after a memory read. A fill therefore returns data older than any store to the same address that loses arbitration to it, and that store then updates the filled line.
- R10: The line index is the low log2(LINES) address bits and the tag is the remaining bits. A fill to an index held by a different tag replaces it, so the earlier address misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core request, held until the response |
| req_write | input | NUM_CORES | Per-core store (1) or load (0) |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address, core i at bits i*ADDR_W |
| req_wdata | input | NUM_CORES*DATA_W | Per-core store data |
| resp_valid | output | NUM_CORES | Per-core single-cycle completion pulse |
| resp_rdata | output | NUM_CORES*DATA_W | Per-core load data, valid with resp_valid |
| mem_wr_en | output | 1 | Memory write strobe from a store broadcast |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe for a fill |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory read data, one cycle after mem_rd_en |

## Verification
The bench uses three cores, 8-bit addresses, 16-bit data and four lines. With three requesters, a full three-way tie can be created, so the fixed grant order is visible in the sequence of memory writes. Because there are only four lines, addresses with different tags pile onto one index. This makes replacement, snoop tag mismatches and the fill-against-store race on a single line easy to set up with a few directed calls.

// File: rtl/wu_pkg.sv
package wu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_RREQ,
    ST_FWAIT,
    ST_FDATA,
    ST_DONE
  } wu_state_e;

endpackage

// File: rtl/wu_line_store.sv
module wu_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  p_idx,
  output logic              p_valid,
  output logic [TAG_W-1:0]  p_tag,
  output logic [DATA_W-1:0] p_rdata,
  input  logic [IDX_W-1:0]  s_idx,
  output logic              s_valid,
  output logic [TAG_W-1:0]  s_tag
);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_ram [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) data_ram[wr_idx] <= wr_data;
    p_rdata <= data_ram[p_idx];
  end

  assign p_valid = valid_q[p_idx];
  assign p_tag   = tag_q[p_idx];
  assign s_valid = valid_q[s_idx];
  assign s_tag   = tag_q[s_idx];

endmodule

// File: rtl/wu_cache_ctrl.sv
module wu_cache_ctrl
  import wu_pkg::*;
#(
  parameter int ID     = 0,
  parameter int ID_W   = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_valid,
  input  logic              proc_write,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [DATA_W-1:0] proc_wdata,
  output logic              proc_resp,
  output logic [DATA_W-1:0] proc_rdata,
  output logic              bus_req,
  output logic              bus_req_wr,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_gnt,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ID_W-1:0]   bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] mem_rd_data
);

  wu_state_e st_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;
  logic [DATA_W-1:0] fill_data_q;
  logic              sel_fill_q;
  logic              resp_q;

  logic              p_valid, s_valid;
  logic [TAG_W-1:0]  p_tag, s_tag;
  logic [DATA_W-1:0] p_rdata;
  logic              p_hit;
  logic              apply_own, apply_snoop, do_fill;
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [TAG_W-1:0]  st_wr_tag;
  logic [DATA_W-1:0] st_wr_data;

  assign p_hit = p_valid && (p_tag == proc_addr[ADDR_W-1:IDX_W]);

  // bus application: own broadcast allocates, foreign one updates only a held copy
  assign apply_own   = bus_vld && bus_wr && (bus_id == ID_W'(ID));
  assign apply_snoop = bus_vld && bus_wr && (bus_id != ID_W'(ID)) && s_valid &&
                       (s_tag == bus_addr[ADDR_W-1:IDX_W]);
  assign do_fill     = (st_q == ST_FDATA);

  always_comb begin
    st_wr_en   = do_fill || apply_own || apply_snoop;
    st_wr_idx  = bus_addr[IDX_W-1:0];
    st_wr_tag  = bus_addr[ADDR_W-1:IDX_W];
    st_wr_data = bus_data;
    if (do_fill) begin
      st_wr_idx  = lat_addr_q[IDX_W-1:0];
      st_wr_tag  = lat_addr_q[ADDR_W-1:IDX_W];
      st_wr_data = mem_rd_data;
    end
  end

  wu_line_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) i_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (st_wr_en),
    .wr_idx (st_wr_idx),
    .wr_tag (st_wr_tag),
    .wr_data(st_wr_data),
    .p_idx  (proc_addr[IDX_W-1:0]),
    .p_valid(p_valid),
    .p_tag  (p_tag),
    .p_rdata(p_rdata),
    .s_idx  (bus_addr[IDX_W-1:0]),
    .s_valid(s_valid),
    .s_tag  (s_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      resp_q      <= 1'b0;
      sel_fill_q  <= 1'b0;
      lat_addr_q  <= '0;
      lat_data_q  <= '0;
      fill_data_q <= '0;
    end else begin
      resp_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (proc_valid) begin
          lat_addr_q <= proc_addr;
          lat_data_q <= proc_wdata;
          if (proc_write) begin
            st_q <= ST_WREQ;
          end else if (p_hit) begin
            st_q       <= ST_DONE;
            resp_q     <= 1'b1;
            sel_fill_q <= 1'b0;
          end else begin
            st_q <= ST_RREQ;
          end
        end
        ST_WREQ: if (bus_gnt) begin
          st_q   <= ST_DONE;
          resp_q <= 1'b1;
        end
        ST_RREQ: if (bus_gnt) st_q <= ST_FWAIT;
        ST_FWAIT: st_q <= ST_FDATA;
        ST_FDATA: begin
          st_q        <= ST_DONE;
          resp_q      <= 1'b1;
          sel_fill_q  <= 1'b1;
          fill_data_q <= mem_rd_data;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req      = (st_q == ST_WREQ) || (st_q == ST_RREQ);
  assign bus_req_wr   = (st_q == ST_WREQ);
  assign bus_req_addr = lat_addr_q;
  assign bus_req_data = lat_data_q;
  assign proc_resp    = resp_q;
  assign proc_rdata   = sel_fill_q ? fill_data_q : p_rdata;

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FDATA) |-> !bus_vld); // R9
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    proc_resp |=> !proc_resp); // R2
  AST_STORE_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WREQ && bus_gnt) |=> (bus_vld && bus_wr && bus_id == ID_W'(ID))); // R4

endmodule

// File: rtl/wu_bus_arbiter.sv
module wu_bus_arbiter #(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CORES-1:0]          req,
  input  logic [NUM_CORES-1:0]          req_wr,
  input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
  input  logic [NUM_CORES*DATA_W-1:0]   req_data,
  output logic [NUM_CORES-1:0]          gnt,
  output logic                          bus_vld,
  output logic                          bus_wr,
  output logic [ID_W-1:0]               bus_id,
  output logic [ADDR_W-1:0]             bus_addr,
  output logic [DATA_W-1:0]             bus_data
);

  logic            lock;
  logic            found;
  logic [ID_W-1:0] win;

  // a memory read holds the bus for one more cycle so its data returns first
  assign lock = bus_vld && !bus_wr;

  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (!found && !lock && req[i]) begin
        gnt[i] = 1'b1;
        win    = ID_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_vld  <= 1'b0;
      bus_wr   <= 1'b0;
      bus_id   <= '0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      bus_vld <= found;
      if (found) begin
        bus_wr   <= req_wr[win];
        bus_id   <= win;
        bus_addr <= req_addr[win*ADDR_W +: ADDR_W];
        bus_data <= req_data[win*DATA_W +: DATA_W];
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R8
  AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0); // R8
  AST_GNT_TO_BUS: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0) |=> bus_vld); // R8

endmodule

// File: rtl/wu_coherent_cluster.sv
module wu_coherent_cluster #(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LINES     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        req_valid,
  input  logic [NUM_CORES-1:0]        req_write,
  input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
  input  logic [NUM_CORES*DATA_W-1:0] req_wdata,
  output logic [NUM_CORES-1:0]        resp_valid,
  output logic [NUM_CORES*DATA_W-1:0] resp_rdata,
  output logic                        mem_wr_en,
  output logic [ADDR_W-1:0]           mem_wr_addr,
  output logic [DATA_W-1:0]           mem_wr_data,
  output logic                        mem_rd_en,
  output logic [ADDR_W-1:0]           mem_rd_addr,
  input  logic [DATA_W-1:0]           mem_rd_data
);

  localparam int ID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0]        bus_req, bus_req_wr, bus_gnt;
  logic [NUM_CORES*ADDR_W-1:0] bus_req_addr;
  logic [NUM_CORES*DATA_W-1:0] bus_req_data;
  logic                        bus_vld, bus_wr;
  logic [ID_W-1:0]             bus_id;
  logic [ADDR_W-1:0]           bus_addr;
  logic [DATA_W-1:0]           bus_data;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    wu_cache_ctrl #(
      .ID    (c),
      .ID_W  (ID_W),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .LINES (LINES)
    ) i_ctrl (
      .clk         (clk),
      .rst         (rst),
      .proc_valid  (req_valid[c]),
      .proc_write  (req_write[c]),
      .proc_addr   (req_addr[c*ADDR_W +: ADDR_W]),
      .proc_wdata  (req_wdata[c*DATA_W +: DATA_W]),
      .proc_resp   (resp_valid[c]),
      .proc_rdata  (resp_rdata[c*DATA_W +: DATA_W]),
      .bus_req     (bus_req[c]),
      .bus_req_wr  (bus_req_wr[c]),
      .bus_req_addr(bus_req_addr[c*ADDR_W +: ADDR_W]),
      .bus_req_data(bus_req_data[c*DATA_W +: DATA_W]),
      .bus_gnt     (bus_gnt[c]),
      .bus_vld     (bus_vld),
      .bus_wr      (bus_wr),
      .bus_id      (bus_id),
      .bus_addr    (bus_addr),
      .bus_data    (bus_data),
      .mem_rd_data (mem_rd_data)
    );
  end

  wu_bus_arbiter #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) i_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (bus_req),
    .req_wr  (bus_req_wr),
    .req_addr(bus_req_addr),
    .req_data(bus_req_data),
    .gnt     (bus_gnt),
    .bus_vld (bus_vld),
    .bus_wr  (bus_wr),
    .bus_id  (bus_id),
    .bus_addr(bus_addr),
    .bus_data(bus_data)
  );

  assign mem_wr_en   = bus_vld && bus_wr;
  assign mem_wr_addr = bus_addr;
  assign mem_wr_data = bus_data;
  assign mem_rd_en   = bus_vld && !bus_wr;
  assign mem_rd_addr = bus_addr;

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && mem_rd_en)); // R9
  AST_RD_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !(mem_wr_en || mem_rd_en)); // R9

endmodule

// File: tb/test_wu_coherent_cluster.sv
`timescale 1ns/1ps
module test_wu_coherent_cluster;

  localparam int NC = 3;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_write = '0;
  logic [NC*AW-1:0] req_addr  = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]    resp_valid;
  logic [NC*DW-1:0] resp_rdata;
  logic             mem_wr_en, mem_rd_en;
  logic [AW-1:0]    mem_wr_addr, mem_rd_addr;
  logic [DW-1:0]    mem_wr_data;
  logic [DW-1:0]    mem_rd_data;

  always #2 clk = ~clk;

  wu_coherent_cluster #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .LINES(4)) i_wu_coherent_cluster (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return 16'hA000 ^ DW'(a * 37);
  endfunction

  // memory model and bus monitor
  logic [DW-1:0] mem [256];
  int rd_cnt, wr_cnt, wr_log_n, rd_wr_back;
  logic [AW-1:0] wr_log_a [16];
  logic [DW-1:0] wr_log_d [16];
  logic prev_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      rd_cnt <= 0; wr_cnt <= 0; wr_log_n <= 0; rd_wr_back <= 0; prev_rd <= 1'b0;
    end else begin
      prev_rd <= mem_rd_en;
      if (mem_rd_en) begin
        mem_rd_data <= mem[mem_rd_addr];
        rd_cnt <= rd_cnt + 1;
      end
      if (mem_wr_en) begin
        mem[mem_wr_addr] <= mem_wr_data;
        wr_cnt <= wr_cnt + 1;
        if (wr_log_n < 16) begin
          wr_log_a[wr_log_n] <= mem_wr_addr;
          wr_log_d[wr_log_n] <= mem_wr_data;
        end
        wr_log_n <= wr_log_n + 1;
        if (prev_rd) rd_wr_back <= rd_wr_back + 1;
      end
    end
  end

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input int c, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] q, output int cyc);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!resp_valid[c] && cyc < 200);
    q = resp_rdata[c*DW +: DW];
    req_valid[c] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "resp_valid after reset", 32'(resp_valid), 0);
    chk("R1", "mem_rd_en after reset", 32'(mem_rd_en), 0);
    chk("R1", "mem_wr_en after reset", 32'(mem_wr_en), 0);
  endtask

  task automatic t_miss_hit();
    logic [DW-1:0] q; int cyc; int r0;
    r0 = rd_cnt;
    do_op(0, 0, 8'h10, 0, q, cyc);
    chk("R1", "first load reads memory", 32'(rd_cnt - r0), 1);
    chk("R3", "miss data", 32'(q), 32'(init_val(8'h10)));
    r0 = rd_cnt;
    do_op(0, 0, 8'h10, 0, q, cyc);
    chk("R3", "repeat load hits", 32'(rd_cnt - r0), 0);
    chk("R2", "hit data", 32'(q), 32'(init_val(8'h10)));
    chk("R2", "hit latency", 32'(cyc), 1);
  endtask

  task automatic t_update();
    logic [DW-1:0] q; int cyc; int r0, w0;
    do_op(0, 0, 8'h20, 0, q, cyc);
    do_op(1, 0, 8'h20, 0, q, cyc);
    w0 = wr_cnt;
    do_op(0, 1, 8'h20, 16'hBEEF, q, cyc);
    repeat (2) @(negedge clk);
    chk("R4", "one memory write", 32'(wr_cnt - w0), 1);
    chk("R4", "write address", 32'(wr_log_a[wr_log_n-1]), 32'h20);
    chk("R4", "write data", 32'(wr_log_d[wr_log_n-1]), 32'hBEEF);
    r0 = rd_cnt;
    do_op(1, 0, 8'h20, 0, q, cyc);
    chk("R5", "sharer sees new value", 32'(q), 32'hBEEF);
    chk("R5", "sharer load hits", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_no_alloc();
    logic [DW-1:0] q; int cyc; int r0;
    do_op(0, 1, 8'h30, 16'h1234, q, cyc);
    repeat (2) @(negedge clk);
    r0 = rd_cnt;
    do_op(2, 0, 8'h30, 0, q, cyc);
    chk("R6", "non-holder misses", 32'(rd_cnt - r0), 1);
    chk("R6", "non-holder data from memory", 32'(q), 32'h1234);
    r0 = rd_cnt;
    do_op(0, 0, 8'h30, 0, q, cyc);
    chk("R7", "store miss allocated", 32'(rd_cnt - r0), 0);
    chk("R7", "allocated data", 32'(q), 32'h1234);
  endtask

  task automatic t_priority();
    logic [DW-1:0] q0, q1, q2; int c0, c1, c2; int n0, r0;
    n0 = wr_log_n;
    fork
      do_op(0, 1, 8'h44, 16'h0A0A, q0, c0);
      do_op(1, 1, 8'h44, 16'h0B0B, q1, c1);
      do_op(2, 1, 8'h44, 16'h0C0C, q2, c2);
    join
    repeat (3) @(negedge clk);
    chk("R8", "three writes", 32'(wr_log_n - n0), 3);
    chk("R8", "first is core0", 32'(wr_log_d[n0]), 32'h0A0A);
    chk("R8", "second is core1", 32'(wr_log_d[n0+1]), 32'h0B0B);
    chk("R8", "third is core2", 32'(wr_log_d[n0+2]), 32'h0C0C);
    r0 = rd_cnt;
    for (int c = 0; c < NC; c++) begin
      do_op(c, 0, 8'h44, 0, q0, c0);
      chk("R8", $sformatf("core%0d final value", c), 32'(q0), 32'h0C0C);
    end
    chk("R8", "final loads all hit", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_fill_race();
    logic [DW-1:0] q0, q1; int c0, c1; int r0, bb;
    r0 = rd_cnt; bb = rd_wr_back;
    fork
      do_op(0, 0, 8'h58, 0, q0, c0);
      do_op(1, 1, 8'h58, 16'h7777, q1, c1);
    join
    repeat (3) @(negedge clk);
    chk("R9", "fill returns older value", 32'(q0), 32'(init_val(8'h58)));
    chk("R9", "no write right after read", 32'(rd_wr_back - bb), 0);
    do_op(0, 0, 8'h58, 0, q0, c0);
    chk("R9", "filled line updated by store", 32'(q0), 32'h7777);
    chk("R9", "only one memory read", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_conflict();
    logic [DW-1:0] q; int cyc; int r0;
    r0 = rd_cnt;
    do_op(1, 0, 8'h61, 0, q, cyc);
    chk("R10", "first address data", 32'(q), 32'(init_val(8'h61)));
    do_op(1, 0, 8'hA1, 0, q, cyc);
    chk("R10", "conflicting address data", 32'(q), 32'(init_val(8'hA1)));
    do_op(1, 0, 8'h61, 0, q, cyc);
    chk("R10", "evicted address data", 32'(q), 32'(init_val(8'h61)));
    chk("R10", "three misses", 32'(rd_cnt - r0), 3);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss_hit();
    t_update();
    t_no_alloc();
    t_priority();
    t_fill_race();
    t_conflict();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule